// File: doc/BRIEF.md
# Interval Timer Byte-Port Front End

This block is the byte-wide register interface of a three-channel interval timer. The bus side has a 2-bit address, an 8-bit write path and an 8-bit read path, each with its own strobe. Address 3 takes control words. Addresses 0 to 2 are the data ports of the three channels. Counting happens elsewhere. For each channel this block emits a one-cycle load pulse with a 16-bit start value, and it takes in the channel's live count and its output level.

A control word does one of three things. It reprograms a channel (access style, operating mode, BCD flag). It freezes a channel's count for a later read. Or it acts as a read-back command that can freeze the count, the status byte, or both, on any set of channels at once. The block splits 16-bit counts into bytes for reads and assembles bytes into counts for writes, following the access style programmed for the channel.

Top module: `itmr_bus_front`

## Requirements
- R1: After reset, every channel has access style 1 (low byte only), mode 0 and BCD 0. No count or status latch is pending and no load pulse is issued. A data-port read returns the low byte of the live count.
- R2: A control word is decoded as follows: bits 7:6 are the channel, bits 5:4 the access style, bits 3:1 the mode and bit 0 BCD. Mode values 6 and 7 are stored as 2 and 3.
- R3: With access style 1, a data write of v gives a load pulse one cycle later with value {8'h00, v}. Only the addressed channel pulses.
- R4: With access style 2, a data write of v loads {v, 8'h00}.
- R5: With access style 3, the first data write is held and produces no load. The second write loads {second, first}.
- R6: A control word that programs a channel returns both its write and its read byte phase to the low byte.
- R7: Access field 0 snapshots the channel's live count and leaves access style, mode and BCD unchanged. It is ignored while a count snapshot is still pending.
- R8: A pending snapshot is read out in the access order: style 1 gives the low byte, style 2 the high byte, style 3 the low byte then the high byte. The latch is freed after its last byte, and reads then return the live count again. Reading latched bytes does not move the live read phase.
- R9: With no latch pending, a read returns a live byte: style 1 the low byte, style 2 the high byte, style 3 the low and high bytes alternately.
- R10: A channel field of 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 at 0 requests a count snapshot and bit 4 at 0 requests a status snapshot, for every selected channel in the same cycle.
- R11: The status byte is {OUT, 0, access[1:0], mode[2:0], BCD}. A pending status is returned before a pending count and is cleared by that read. Count and status latches are held separately, so both can be pending at once.
- R12: A data write and a data read to the same port in one cycle both take effect. The read uses the read phase and latch state from before the edge, and the write advances only the write phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | 0-2 channel data port, 3 control word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high, for the current state |
| ld_stb | output | NCH | Per-channel load pulse |
| ld_val | output | NCH*16 | Per-channel load value, channel i at bits i*16 +: 16 |
| live_cnt | input | NCH*16 | Per-channel live count from the counters |
| live_out | input | NCH | Per-channel output level |

## Verification
Two functions can meet in one cycle. The first case is a data write and a data read on the same port. The bench drives both strobes together on a word-mode channel and checks two things: the read byte follows the old read phase, and the load pulse carries the bytes in write-phase order. The second case is a single read-back command that latches status and count together on one channel, or counts on two channels at once. The bench changes the live counts right after the command and checks that status comes first, then the frozen bytes, then the new live value.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chcfg_t;

  localparam logic [1:0] SEL_RDBK = 2'd3;

  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m[2] & m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/itmr_ctl_decode.sv
module itmr_ctl_decode
  import itmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8
) (
  input  logic          ctl_wr,
  input  logic [DW-1:0] ctl_byte,
  output logic [NCH-1:0] cfg_we,
  output chcfg_t         cfg_new,
  output logic [NCH-1:0] cnt_req,
  output logic [NCH-1:0] st_req
);
  logic [1:0] sel;
  acc_e       acc;
  logic       is_rdbk;

  always_comb begin
    sel          = ctl_byte[7:6];
    acc          = acc_e'(ctl_byte[5:4]);
    is_rdbk      = (sel == SEL_RDBK);
    cfg_new.acc  = acc;
    cfg_new.mode = fold_mode(ctl_byte[3:1]);
    cfg_new.bcd  = ctl_byte[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    logic mask_bit;
    assign hit       = ctl_wr && !is_rdbk && (sel == 2'(i));
    assign mask_bit  = ctl_wr && is_rdbk && ctl_byte[i+1];
    assign cfg_we[i]  = hit && (acc != ACC_LATCH);
    assign cnt_req[i] = (hit && (acc == ACC_LATCH)) || (mask_bit && !ctl_byte[5]);
    assign st_req[i]  = mask_bit && !ctl_byte[4];
  end
endmodule

// File: rtl/itmr_chan_port.sv
module itmr_chan_port
  import itmr_pkg::*;
#(
  parameter int DW = 8,
  localparam int CW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  chcfg_t        cfg_new,
  input  logic          cnt_req,
  input  logic          st_req,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  input  logic [CW-1:0] live_cnt,
  input  logic          live_out,
  output logic [DW-1:0] rd_byte,
  output logic          ld_stb,
  output logic [CW-1:0] ld_val
);
  chcfg_t        cfg_q, cfg_d;
  logic          wph_q, wph_d;
  logic          rph_q, rph_d;
  logic [DW-1:0] hold_q, hold_d;
  logic [CW-1:0] snap_q, snap_d;
  acc_e          cl_q, cl_d;
  logic [DW-1:0] st_q, st_d;
  logic          stp_q, stp_d;
  logic          ld_d;
  logic [CW-1:0] ldv_d;
  logic          cfg_en, snap_en, st_en;

  assign cfg_en  = cfg_we;
  assign snap_en = cnt_req && (cl_q == ACC_LATCH);
  assign st_en   = st_req && !stp_q;

  always_comb begin
    wph_d  = wph_q;
    rph_d  = rph_q;
    hold_d = hold_q;
    cl_d   = cl_q;
    stp_d  = stp_q;
    ld_d   = 1'b0;
    ldv_d  = ld_val;
    cfg_d  = cfg_new;
    snap_d = live_cnt;
    st_d   = {live_out, 1'b0, cfg_q.acc, cfg_q.mode, cfg_q.bcd};

    if (dat_rd) begin
      if (stp_q) begin
        stp_d = 1'b0;
      end else if (cl_q != ACC_LATCH) begin
        cl_d = (cl_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
      end else if (cfg_q.acc == ACC_WORD) begin
        rph_d = ~rph_q;
      end
    end

    if (dat_wr) begin
      unique case (cfg_q.acc)
        ACC_HI: begin
          ld_d  = 1'b1;
          ldv_d = {wdata, {DW{1'b0}}};
        end
        ACC_WORD: begin
          if (!wph_q) begin
            hold_d = wdata;
            wph_d  = 1'b1;
          end else begin
            ld_d  = 1'b1;
            ldv_d = {wdata, hold_q};
            wph_d = 1'b0;
          end
        end
        default: begin
          ld_d  = 1'b1;
          ldv_d = {{DW{1'b0}}, wdata};
        end
      endcase
    end

    if (snap_en) cl_d  = cfg_q.acc;
    if (st_en)   stp_d = 1'b1;
    if (cfg_en) begin
      wph_d = 1'b0;
      rph_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{acc: ACC_LO, mode: 3'd0, bcd: 1'b0};
      wph_q  <= 1'b0;
      rph_q  <= 1'b0;
      hold_q <= '0;
      snap_q <= '0;
      cl_q   <= ACC_LATCH;
      st_q   <= '0;
      stp_q  <= 1'b0;
      ld_stb <= 1'b0;
      ld_val <= '0;
    end else begin
      if (cfg_en)  cfg_q  <= cfg_d;
      if (snap_en) snap_q <= snap_d;
      if (st_en)   st_q   <= st_d;
      wph_q  <= wph_d;
      rph_q  <= rph_d;
      hold_q <= hold_d;
      cl_q   <= cl_d;
      stp_q  <= stp_d;
      ld_stb <= ld_d;
      ld_val <= ldv_d;
    end
  end

  always_comb begin
    if (stp_q) begin
      rd_byte = st_q;
    end else if (cl_q != ACC_LATCH) begin
      rd_byte = (cl_q == ACC_HI) ? snap_q[CW-1:DW] : snap_q[DW-1:0];
    end else begin
      unique case (cfg_q.acc)
        ACC_HI:   rd_byte = live_cnt[CW-1:DW];
        ACC_WORD: rd_byte = rph_q ? live_cnt[CW-1:DW] : live_cnt[DW-1:0];
        default:  rd_byte = live_cnt[DW-1:0];
      endcase
    end
  end

  assert_status_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stp_q && !dat_rd) |=> (stp_q && $stable(st_q)));
  assert_snapshot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_q != ACC_LATCH) |=> $stable(snap_q));
  assert_load_follows_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |-> $past(dat_wr));
  assert_first_byte_no_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_wr && cfg_q.acc == ACC_WORD && !wph_q) |=> !ld_stb);
  assert_status_mode_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stp_q |-> (st_q[3:1] <= 3'd5));
endmodule

// File: rtl/itmr_bus_front.sv
module itmr_bus_front
  import itmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 8,
  localparam int CW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic [NCH-1:0]   ld_stb,
  output logic [NCH*CW-1:0] ld_val,
  input  logic [NCH*CW-1:0] live_cnt,
  input  logic [NCH-1:0]   live_out
);
  logic rst_meta, rst_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [NCH-1:0] cfg_we, cnt_req, st_req;
  chcfg_t         cfg_new;
  logic [DW-1:0]  rd_byte [NCH];
  logic           ctl_wr;

  assign ctl_wr = bus_wr && (bus_addr == SEL_RDBK);

  itmr_ctl_decode #(.NCH(NCH), .DW(DW)) u_dec (
    .ctl_wr   (ctl_wr),
    .ctl_byte (bus_wdata),
    .cfg_we   (cfg_we),
    .cfg_new  (cfg_new),
    .cnt_req  (cnt_req),
    .st_req   (st_req)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    logic port_hit;
    assign port_hit = (bus_addr == 2'(i));
    itmr_chan_port #(.DW(DW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_sync),
      .cfg_we   (cfg_we[i]),
      .cfg_new  (cfg_new),
      .cnt_req  (cnt_req[i]),
      .st_req   (st_req[i]),
      .dat_wr   (bus_wr && port_hit),
      .dat_rd   (bus_rd && port_hit),
      .wdata    (bus_wdata),
      .live_cnt (live_cnt[i*CW +: CW]),
      .live_out (live_out[i]),
      .rd_byte  (rd_byte[i]),
      .ld_stb   (ld_stb[i]),
      .ld_val   (ld_val[i*CW +: CW])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == 2'(i)) bus_rdata = rd_byte[i];
    end
  end

  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    $onehot0(ld_stb));
  assert_ctl_no_load_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    ctl_wr |=> (ld_stb == '0));
endmodule

// File: tb/itmr_bus_front_tb.sv
`timescale 1ns/1ps
module itmr_bus_front_tb;
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       bus_addr;
  logic             bus_wr, bus_rd;
  logic [7:0]       bus_wdata;
  logic [7:0]       bus_rdata;
  logic [NCH-1:0]   ld_stb;
  logic [NCH*CW-1:0] ld_val;
  logic [CW-1:0]    live [NCH];
  logic [NCH-1:0]   live_out;
  logic [NCH*CW-1:0] live_flat;

  always #2.5 clk = ~clk;
  assign live_flat = {live[2], live[1], live[0]};

  itmr_bus_front u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ld_stb(ld_stb), .ld_val(ld_val),
    .live_cnt(live_flat), .live_out(live_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]  rd_q [$];
  string       rd_tag [$];
  logic [17:0] ld_q [$];
  string       ld_tag [$];

  function automatic logic [7:0] ctl(int ch, int acc, int mode, int bcd);
    return {2'(ch), 2'(acc), 3'(mode), 1'(bcd)};
  endfunction
  function automatic logic [7:0] rdbk(bit cnt, bit st, logic [2:0] mask);
    return {2'b11, ~cnt, ~st, mask, 1'b0};
  endfunction
  function automatic logic [7:0] stat(bit o, int acc, int mode, int bcd);
    return {o, 1'b0, 2'(acc), 3'(mode), 1'(bcd)};
  endfunction

  task automatic cyc(bit w, bit r, int a, logic [7:0] d);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = 2'(a); bus_wdata = d;
  endtask
  task automatic wr(int a, logic [7:0] d);
    cyc(1, 0, a, d);
  endtask
  task automatic rd(int ch, logic [7:0] e, string tag);
    rd_q.push_back(e); rd_tag.push_back(tag);
    cyc(0, 1, ch, 8'h00);
  endtask
  task automatic wrrd(int ch, logic [7:0] d, logic [7:0] e, string tag);
    rd_q.push_back(e); rd_tag.push_back(tag);
    cyc(1, 1, ch, d);
  endtask
  task automatic exp_ld(int ch, logic [15:0] v, string tag);
    ld_q.push_back({2'(ch), v}); ld_tag.push_back(tag);
  endtask
  task automatic set_live(int ch, logic [15:0] v);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
    live[ch] = v;
  endtask

  // monitor: compares read bytes and load pulses against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (bus_rd === 1'b1) begin
        n_cmp++;
        if (rd_q.size() == 0) begin
          n_bad++;
          $display("FAIL unexpected read act=%h exp=none", bus_rdata);
        end else begin
          logic [7:0] e;
          string t;
          e = rd_q.pop_front(); t = rd_tag.pop_front();
          if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL %s read port %0d act=%h exp=%h", t, bus_addr, bus_rdata, e);
          end
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (ld_stb[i] === 1'b1) begin
          n_cmp++;
          if (ld_q.size() == 0) begin
            n_bad++;
            $display("FAIL R5 unexpected load ch%0d act=%h exp=none", i, ld_val[i*CW +: CW]);
          end else begin
            logic [17:0] e;
            string t;
            e = ld_q.pop_front(); t = ld_tag.pop_front();
            if (e[17:16] != 2'(i) || ld_val[i*CW +: CW] !== e[15:0]) begin
              n_bad++;
              $display("FAIL %s load ch%0d act=%h exp=ch%0d %h", t, i,
                       ld_val[i*CW +: CW], e[17:16], e[15:0]);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    live[0] = 16'h1234; live[1] = 16'hABCD; live[2] = 16'h5A0F;
    live_out = 3'b011;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_cmp++;
    if (ld_stb !== 3'b000) begin
      n_bad++;
      $display("FAIL R1 load strobe after reset act=%b exp=000", ld_stb);
    end
    // R1 / R9: reset access style is low byte, no toggling
    rd(0, 8'h34, "R1");
    rd(0, 8'h34, "R9");
    // R3: low-byte load
    wr(3, ctl(0, 1, 2, 0));
    wr(0, 8'h55); exp_ld(0, 16'h0055, "R3");
    // R4: high-byte load, live high read
    wr(3, ctl(0, 2, 0, 0));
    wr(0, 8'h66); exp_ld(0, 16'h6600, "R4");
    rd(0, 8'h12, "R9");
    // R5: word load, mode 6 folds to 2
    wr(3, ctl(2, 3, 6, 0));
    wr(2, 8'h11);
    wr(2, 8'h22); exp_ld(2, 16'h2211, "R5");
    rd(2, 8'h0F, "R9");
    rd(2, 8'h5A, "R9");
    rd(2, 8'h0F, "R9");
    // R6: control word resets both phases
    wr(2, 8'h33);
    wr(3, ctl(2, 3, 6, 0));
    rd(2, 8'h0F, "R6");
    wr(2, 8'h44);
    wr(2, 8'h55); exp_ld(2, 16'h5544, "R6");
    // R2 / R11: status read-back on ch2, then live again (phase high)
    wr(3, rdbk(0, 1, 3'b100));
    rd(2, stat(0, 3, 2, 0), "R2");
    rd(2, 8'h5A, "R11");
    // R7 / R8: counter latch, second latch ignored
    wr(3, 8'h80);
    set_live(2, 16'h7777);
    rd(2, 8'h0F, "R7");
    wr(3, 8'h80);
    rd(2, 8'h5A, "R8");
    rd(2, 8'h77, "R8");
    // R11: status and count pending together on ch0
    wr(3, rdbk(1, 1, 3'b001));
    set_live(0, 16'h9876);
    rd(0, stat(1, 2, 0, 0), "R11");
    rd(0, 8'h12, "R11");
    rd(0, 8'h98, "R8");
    // R7: mode retained across a counter latch
    wr(3, ctl(1, 3, 7, 1));
    wr(3, 8'h40);
    wr(3, rdbk(0, 1, 3'b010));
    set_live(1, 16'h1EE1);
    rd(1, stat(1, 3, 3, 1), "R7");
    rd(1, 8'hCD, "R8");
    rd(1, 8'hAB, "R8");
    rd(1, 8'hE1, "R9");
    // R10: one read-back freezes two channels
    wr(3, rdbk(1, 0, 3'b011));
    set_live(0, 16'h4321);
    set_live(1, 16'h2222);
    rd(0, 8'h98, "R10");
    rd(1, 8'hE1, "R10");
    rd(1, 8'h1E, "R10");
    rd(0, 8'h43, "R10");
    rd(1, 8'h22, "R9");
    // R12: write and read on the same port in one cycle
    set_live(2, 16'h3CC3);
    wrrd(2, 8'h99, 8'h3C, "R12");
    wrrd(2, 8'h88, 8'hC3, "R12"); exp_ld(2, 16'h8899, "R12");
    rd(2, 8'h3C, "R12");
    cyc(0, 0, 0, 8'h00);
    repeat (4) @(negedge clk);
    n_cmp++;
    if (rd_q.size() != 0 || ld_q.size() != 0) begin
      n_bad++;
      $display("FAIL R3 leftover items act=%0d exp=0", rd_q.size() + ld_q.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule